// File: doc/BRIEF.md
# Grouped Interrupt Enable Gate

This block sits between a set of level-sensitive interrupt sources and the interrupt controller that consumes them. The input lines are split into groups of consecutive lines, and each group has a map register whose top bit is the group's enable. While a group is enabled, each of its lines is forwarded to the matching output one clock later. While it is disabled, the group's outputs stay low whatever the inputs do.

Software reaches the map registers through a small 32-bit read/write port decoded inside a 64-byte window. Each register owns an 8-byte slot. Only the upper word of the slot, where address bit 2 is set, holds the register. The lower word is a pad that reads as zero and ignores writes. Only the enable bit can be written. The low 31 bits of each register hold a fixed pattern that identifies the register. Reset disables every group and leaves that pattern untouched.

Top module: `irq_group_gate`

## Requirements
- R1: While reset is asserted and right after it, every interrupt output is 0, the read data is 0, and every group enable is clear.
- R2: A read at byte offset 8*n+4 returns 0x7C0 | (n << 2) in bits 30:0, and returns the enable of group n in bit 31.
- R3: A write at byte offset 8*n+4 sets the enable of group n to write-data bit 31. Bits 30:0 of the register keep their value whatever the write data holds.
- R4: At a pad word (address bit 2 clear), a read returns 0 and a write changes no enable. This can be seen on the interrupt outputs and on a later readback.
- R5: While the enable of a line's group is set, that interrupt output equals the line's input as it stood one clock earlier.
- R6: While the enable of a line's group is clear, that interrupt output is 0 one clock later, whatever the input level.
- R7: Map register n governs only input lines 4n to 4n+3. Its enable has no effect on the lines of any other group.
- R8: Read data is updated on the clock edge that samples the read strobe. It then holds its value until the next read strobe. A read in the same cycle as a write returns the value from before the write.
- R9: A reset applied after enables were set clears every enable. Bits 30:0 of every register still read back as the pattern given in R2.
- R10: Address bits 1:0 are ignored. Any byte address inside a 32-bit word reaches that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 6 | Byte address inside the 64-byte window |
| acc_wdata | input | 32 | Write data; only bit 31 is used |
| acc_rdata | output | 32 | Read data, valid the cycle after acc_rd |
| irq_in | input | 32 | Level interrupt inputs |
| irq_out | output | 32 | Gated, registered interrupt outputs |

## Verification
The hardest case to reach from the ports is a reset that arrives after some groups were enabled. It must clear the enables and keep each register's fixed low field intact. The bench first enables a random set of groups and checks that the outputs pass through. It then pulses reset in the middle of the run, and reads every register back to show that only bit 31 changed. Random traffic mixes writes and reads to pad words and map words with random input levels in the same cycle. This exercises the one-cycle lag between a new enable and the output gating, and the rule that a read returns the register as it stood before a write in the same cycle.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

   localparam logic [31:0] ID_PATTERN  = 32'h0000_001F;
   localparam int          ID_SHIFT    = 6;
   localparam int          INDEX_SHIFT = 2;

   function automatic logic [31:0] map_default(input int unsigned idx);
      return (ID_PATTERN << ID_SHIFT) | (32'(idx) << INDEX_SHIFT);
   endfunction

endpackage

// File: rtl/irqmap_decode.sv
module irqmap_decode #(
   parameter int ADDR_W = 6,
   parameter int SLOT_W = 3
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_wr,
   input  logic              acc_rd,
   output logic [SLOT_W-1:0] slot,
   output logic              map_word,
   output logic              map_wr,
   output logic              map_rd
);
   logic unused_byte_lane;

   generate
      if (ADDR_W != SLOT_W + 3) begin : g_bad_width
         $error("irqmap_decode: ADDR_W must equal SLOT_W + 3");
      end
   endgenerate

   assign unused_byte_lane = ^acc_addr[1:0];
   assign slot     = acc_addr[ADDR_W-1:3];
   assign map_word = acc_addr[2];
   assign map_wr   = acc_wr & acc_addr[2];
   assign map_rd   = acc_rd & acc_addr[2];
endmodule

// File: rtl/irqmap_bank.sv
module irqmap_bank
   import irqmap_pkg::*;
#(
   parameter int NUM_GROUPS = 8,
   parameter int DATA_W     = 32,
   parameter int SLOT_W     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SLOT_W-1:0]     slot,
   input  logic                  map_word,
   input  logic                  map_wr,
   input  logic                  acc_rd,
   input  logic [DATA_W-1:0]     acc_wdata,
   output logic [NUM_GROUPS-1:0] grp_en,
   output logic [DATA_W-1:0]     acc_rdata
);
   localparam int LOW_W  = DATA_W - 1;
   localparam int EN_BIT = DATA_W - 1;

   logic [LOW_W-1:0]  low_tab [NUM_GROUPS];
   logic [DATA_W-1:0] rd_word;
   logic              unused_wdata;

   generate
      if (NUM_GROUPS > (1 << SLOT_W)) begin : g_bad_slots
         $error("irqmap_bank: SLOT_W too narrow for NUM_GROUPS");
      end
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_low
         assign low_tab[g] = LOW_W'(map_default(g));
      end
   endgenerate

   assign unused_wdata = ^acc_wdata[LOW_W-1:0];

   // enable bits: the only writable state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_en <= '0;
      end else if (map_wr && (int'(slot) < NUM_GROUPS)) begin
         grp_en[slot] <= acc_wdata[EN_BIT];
      end
   end

   always_comb begin
      rd_word = '0;
      if (map_word && (int'(slot) < NUM_GROUPS)) begin
         rd_word = {grp_en[slot], low_tab[slot]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_rdata <= '0;
      end else if (acc_rd) begin
         acc_rdata <= rd_word;
      end
   end

   // R3: a map-word write lands its bit 31 in the enable of that slot
   a_r3_write_sets_enable: assert property (@(posedge clk) disable iff (!rst_n)
      map_wr |=> (grp_en[$past(slot)] == $past(acc_wdata[EN_BIT])));

   // R4: a cycle without a map-word write leaves every enable unchanged
   a_r4_pad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !map_wr |=> $stable(grp_en));

   // R4: pad-word reads return zero
   a_r4_pad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !map_word) |=> (acc_rdata == '0));

   // R8: read data holds when no read strobe is present
   a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> $stable(acc_rdata));
endmodule

// File: rtl/irqmap_gate.sv
module irqmap_gate #(
   parameter int NUM_GROUPS      = 8,
   parameter int LINES_PER_GROUP = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_GROUPS-1:0]                 grp_en,
   input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_in,
   output logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_out
);
   localparam int L = LINES_PER_GROUP;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_out[g*L +: L] <= '0;
            end else begin
               irq_out[g*L +: L] <= irq_in[g*L +: L] & {L{grp_en[g]}};
            end
         end

         // R6: a disabled group drives low outputs on the next cycle
         a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_en[g] |=> (irq_out[g*L +: L] == '0));

         // R5: an enabled group passes its inputs one cycle later
         a_r5_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
            grp_en[g] |=> (irq_out[g*L +: L] == $past(irq_in[g*L +: L])));
      end
   endgenerate
endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate #(
   parameter int NUM_GROUPS      = 8,
   parameter int LINES_PER_GROUP = 4,
   parameter int DATA_W          = 32,
   parameter int ADDR_W          = 6
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  acc_wr,
   input  logic                                  acc_rd,
   input  logic [ADDR_W-1:0]                     acc_addr,
   input  logic [DATA_W-1:0]                     acc_wdata,
   output logic [DATA_W-1:0]                     acc_rdata,
   input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_in,
   output logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_out
);
   localparam int SLOT_W = $clog2(NUM_GROUPS);

   logic [SLOT_W-1:0]     slot;
   logic                  map_word;
   logic                  map_wr;
   logic                  map_rd;
   logic                  unused_map_rd;
   logic [NUM_GROUPS-1:0] grp_en;

   generate
      if (NUM_GROUPS < 2 || (1 << SLOT_W) != NUM_GROUPS) begin : g_bad_groups
         $error("irq_group_gate: NUM_GROUPS must be a power of two, at least 2");
      end
      if (ADDR_W != SLOT_W + 3) begin : g_bad_addr
         $error("irq_group_gate: ADDR_W must cover 8 bytes per group");
      end
      if (DATA_W < 12) begin : g_bad_data
         $error("irq_group_gate: DATA_W too narrow for the id field");
      end
   endgenerate

   assign unused_map_rd = map_rd;

   irqmap_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_decode (
      .acc_addr (acc_addr),
      .acc_wr   (acc_wr),
      .acc_rd   (acc_rd),
      .slot     (slot),
      .map_word (map_word),
      .map_wr   (map_wr),
      .map_rd   (map_rd)
   );

   irqmap_bank #(.NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (slot),
      .map_word  (map_word),
      .map_wr    (map_wr),
      .acc_rd    (acc_rd),
      .acc_wdata (acc_wdata),
      .grp_en    (grp_en),
      .acc_rdata (acc_rdata)
   );

   irqmap_gate #(.NUM_GROUPS(NUM_GROUPS), .LINES_PER_GROUP(LINES_PER_GROUP)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .grp_en  (grp_en),
      .irq_in  (irq_in),
      .irq_out (irq_out)
   );
endmodule

// File: tb/tb_irq_group_gate.sv
module tb_irq_group_gate;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_wr = 1'b0;
   logic        acc_rd = 1'b0;
   logic [5:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic [31:0] irq_in = '0;
   logic [31:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m_en = '0;

   always #(CLK_P/2) clk = ~clk;

   irq_group_gate dut (
      .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq_in(irq_in), .irq_out(irq_out)
   );

   function automatic logic [31:0] line_mask(input logic [7:0] en);
      logic [31:0] m = '0;
      for (int i = 0; i < 32; i++) m[i] = en[i/4];
      return m;
   endfunction

   function automatic logic [31:0] exp_read(input logic [5:0] a, input logic [7:0] en);
      if (!a[2]) return 32'h0;
      return {en[a[5:3]], 31'(32'h7C0 | (32'(a[5:3]) << 2))};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // one cycle: optional write/read, new input levels; checks outputs afterwards
   task automatic step(input bit wr, input bit rd, input logic [5:0] a,
                       input logic [31:0] wd, input logic [31:0] lv, input string req);
      logic [31:0] e_out, e_rd;
      logic [31:0] old_rd;
      @(negedge clk);
      old_rd = acc_rdata;
      acc_wr = wr; acc_rd = rd; acc_addr = a; acc_wdata = wd; irq_in = lv;
      e_out = lv & line_mask(m_en);
      e_rd  = rd ? exp_read(a, m_en) : old_rd;
      if (wr && a[2]) m_en[a[5:3]] = wd[31];
      @(negedge clk);
      acc_wr = 1'b0; acc_rd = 1'b0;
      check({req, " irq_out"}, irq_out, e_out);
      check({req, " rdata"}, acc_rdata, e_rd);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      // R1: reset state
      repeat (3) @(negedge clk);
      irq_in = '1;
      @(negedge clk);
      check("R1 reset irq_out", irq_out, 32'h0);
      check("R1 reset rdata", acc_rdata, 32'h0);
      rst_n = 1'b1;
      step(0, 0, 6'h0, 0, 32'hFFFF_FFFF, "R1 R6 post-reset all disabled");

      // R2: default readback for every register
      for (int n = 0; n < 8; n++)
         step(0, 1, 6'(n*8+4), 0, 32'h0, "R2 default read");

      // R3: write with all low bits set, only bit 31 should change
      step(1, 0, 6'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 enable grp2");
      step(0, 1, 6'h14, 0, 32'hFFFF_FFFF, "R3 readback grp2 R7 only lines 8-11");
      step(1, 0, 6'h14, 32'h7FFF_FFFF, 32'h0000_0F00, "R3 clear grp2");
      step(0, 1, 6'h14, 0, 32'h0000_0F00, "R3 readback cleared");

      // R4: pad word write/read
      step(1, 0, 6'h08, 32'h8000_0000, 32'hFFFF_FFFF, "R4 pad write");
      step(0, 1, 6'h08, 0, 32'hFFFF_FFFF, "R4 pad read zero, R6 outputs low");
      step(0, 1, 6'h0C, 0, 32'hFFFF_FFFF, "R4 no enable change readback");

      // R10: byte lanes ignored
      step(1, 0, 6'h3F, 32'h8000_0000, 32'hA5A5_A5A5, "R10 write via byte 3");
      step(0, 1, 6'h3D, 0, 32'hF000_0000, "R10 R5 read via byte 1, grp7 passes");

      // R8: read same cycle as write returns old value; hold afterwards
      step(1, 1, 6'h04, 32'h8000_0000, 32'h0000_000F, "R8 read during write");
      step(0, 0, 6'h00, 0, 32'h0000_000F, "R8 hold R5 grp0 passes");

      // random traffic
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r = $urandom;
         step(r[0], r[1], 6'($urandom), $urandom, $urandom, "R5 R6 R7 random");
      end

      // R9: reset with enables set, then readback low fields
      for (int n = 0; n < 8; n++)
         step(1, 0, 6'(n*8+4), 32'h8000_0000, 32'hFFFF_FFFF, "R9 enable all");
      step(0, 0, 6'h0, 0, 32'hFFFF_FFFF, "R9 R5 all pass");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 R1 outputs after reset", irq_out, 32'h0);
      m_en = '0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int n = 0; n < 8; n++)
         step(0, 1, 6'(n*8+4), 0, 32'hFFFF_FFFF, "R9 low field kept, enable clear");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule